// File: doc/BRIEF.md
# 3x3 Convolution Filter Unit

This block is one filter unit of a convolution accelerator. Each operation forms a nine-term dot product between half-precision data values and half-precision weights. The data values come from one wide memory word: each operation picks nine lanes from that word, either consecutive or every second lane. It can force any of the nine taps to zero, so borders are padded and smaller kernels are formed without a padded copy of the input. The weights sit in a register set that the surrounding logic reloads whenever it chooses.

The nine products are summed exactly in a wide two's-complement fixed-point accumulator. A partial sum from a neighbouring unit, in that same fixed-point format, can be added, so several units can be chained into kernels larger than 3x3. The result leaves the unit either rounded once to half precision or as the raw wide accumulator value, which can feed the next unit's chain input. The unit is fully pipelined: one operation per cycle, with a fixed latency of four cycles.

Top module: `conv3_filter_unit`

## Requirements
- R1: While reset is asserted and until the first operation has passed through the pipeline, `res_valid` is 0. `res_value` is 0 during reset.
- R2: `res_valid` rises exactly four clock edges after the edge that sampled `op_valid` high. Back-to-back operations produce back-to-back results in issue order.
- R3: When `op_raw`=0, `res_value[15:0]` is the exact dot product plus the chain input, rounded once to half precision, round-to-nearest with ties to even. Subnormal results are produced, a zero result is +0 (0x0000), and `res_value[ACC_W-1:16]` is 0.
- R4: When `op_raw`=1, `res_value` is the exact sum as a two's-complement fixed-point number with 48 fraction bits, so the value equals `res_value`/2^48.
- R5: `op_chain_in` holds a value in the same 48-fraction-bit format. It is added into the sum of the operation it arrives with.
- R6: Bit t of `op_pad_mask` forces tap t to contribute zero. A masked tap never produces the special-operand result of R11, whatever lane or weight it holds.
- R7: Lane k of `op_data` occupies bits [16k+15:16k]. With `op_skip2`=0, tap t uses lane t. With `op_skip2`=1, tap t uses lane 2t.
- R8: A half-precision operand, data or weight, with exponent field 0 is treated as zero.
- R9: A half-precision result whose magnitude rounds to 2^16 or more is an infinity: 0x7C00 when positive, 0xFC00 when negative.
- R10: `wt_data` is captured when `wt_load`=1. Tap t's weight is bits [16t+15:16t]. An operation uses the weights loaded in its own cycle or earlier, and a load in any later cycle does not alter it.
- R11: An unmasked tap whose data or weight has exponent field 31 makes the half-precision result 0x7E00. In wide mode it contributes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_data | input | LANES*16 | Wide memory word of half-precision lanes |
| op_pad_mask | input | TAPS | Per-tap zero force |
| op_skip2 | input | 1 | Pick every second lane |
| op_raw | input | 1 | 1: wide fixed-point result, 0: half-precision result |
| op_chain_in | input | ACC_W | Partial sum from a neighbouring unit |
| wt_load | input | 1 | Capture new weights |
| wt_data | input | TAPS*16 | Nine half-precision weights |
| res_valid | output | 1 | Result valid |
| res_value | output | ACC_W | Result, half precision in bits [15:0] or wide |

## Verification
The bench aims at rounding ties and sums just above a tie. A design that rounded away from zero, or that rounded twice through single precision, would return a half-precision code one unit too high. It drives tiny products that land in the subnormal output range and products that overflow past the largest finite value. A unit that lost the subnormal path would return zero or a wrong exponent, and one without saturation would wrap into a NaN pattern. It mixes the pad mask, the skip-two lane selection, special operands placed behind masked taps, and weight reloads in the same cycle as an operation and in the cycle after it. Wrong lane wiring, leaking masks or weights applied at the wrong stage each show up as a wrong value in the cycle the reference model predicts. A long stream of back-to-back random operations in both output formats exposes any pipeline register that skips or repeats a stage.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
   localparam int FP_W      = 16;
   localparam int EXP_W     = 5;
   localparam int MAN_W     = 10;
   localparam int EXP_BIAS  = 15;
   // fraction bits needed to hold the smallest product of two normal values exactly
   localparam int FRAC_W    = 2 * (EXP_BIAS - 1 + MAN_W);
   // shift offset from (ea + eb) to the product's position on the fixed-point grid
   localparam int PROD_OFS  = 2 * (EXP_BIAS + MAN_W) - FRAC_W;
   localparam int ACC_MIN_W = FRAC_W + 40;
   localparam logic [FP_W-1:0] FP_QNAN = 16'h7E00;
   localparam logic [FP_W-1:0] FP_INF  = 16'h7C00;

   typedef struct packed {
      logic             sgn;
      logic [EXP_W-1:0] ex;
      logic [MAN_W-1:0] man;
   } half_t;
endpackage

// File: rtl/conv3_operand_load.sv
module conv3_operand_load
   import conv3_pkg::*;
#(
   parameter int TAPS    = 9,
   parameter int LANES   = 17,
   parameter bit SKIP_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld,
   input  logic [LANES*FP_W-1:0]      data,
   input  logic [TAPS-1:0]            pad_mask,
   input  logic                       skip2,
   output logic [TAPS-1:0][FP_W-1:0]  x_q,
   output logic [TAPS-1:0]            live_q
);
   logic [TAPS-1:0][FP_W-1:0] pick;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      if (SKIP_EN) begin : g_skip
         assign pick[t] = skip2 ? data[2*t*FP_W +: FP_W] : data[t*FP_W +: FP_W];
      end else begin : g_flat
         assign pick[t] = data[t*FP_W +: FP_W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            x_q[t]    <= '0;
            live_q[t] <= 1'b0;
         end else if (ld) begin
            x_q[t]    <= pad_mask[t] ? '0 : pick[t];
            live_q[t] <= ~pad_mask[t];
         end
      end
   end
endmodule

// File: rtl/conv3_product_stage.sv
module conv3_product_stage
   import conv3_pkg::*;
#(
   parameter int TAPS  = 9,
   parameter int ACC_W = 96
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wt_load,
   input  logic [TAPS*FP_W-1:0]        wt_data,
   input  logic [TAPS-1:0][FP_W-1:0]   x_q,
   input  logic [TAPS-1:0]             live_q,
   output logic [TAPS-1:0][ACC_W-1:0]  prod_q,
   output logic                        nan_q
);
   localparam int SIG_W = MAN_W + 1;
   localparam int PM_W  = 2 * SIG_W;

   logic [TAPS-1:0][FP_W-1:0]  w_q;
   logic [TAPS-1:0][ACC_W-1:0] prod_d;
   logic [TAPS-1:0]            tap_nan;

   for (genvar t = 0; t < TAPS; t++) begin : g_mul
      half_t            a, b;
      logic [SIG_W-1:0] sa, sb;
      logic [PM_W-1:0]  pm;
      logic [6:0]       sh;
      logic [ACC_W-1:0] mag;
      logic             a_spec, b_spec;

      always_ff @(posedge clk) begin
         if (!rst_n)       w_q[t] <= '0;
         else if (wt_load) w_q[t] <= wt_data[t*FP_W +: FP_W];
      end

      always_comb begin
         a      = half_t'(x_q[t]);
         b      = half_t'(w_q[t]);
         a_spec = &a.ex;
         b_spec = &b.ex;
         // exponent 0 flushes to zero; exponent 31 carries no magnitude
         sa     = (a.ex == '0 || a_spec) ? '0 : {1'b1, a.man};
         sb     = (b.ex == '0 || b_spec) ? '0 : {1'b1, b.man};
         pm     = sa * sb;
         sh     = 7'(a.ex) + 7'(b.ex) - 7'(PROD_OFS);
         mag    = ACC_W'(pm) << sh;
         prod_d[t]  = (a.sgn ^ b.sgn) ? (~mag + ACC_W'(1)) : mag;
         tap_nan[t] = live_q[t] & (a_spec | b_spec);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q <= '0;
         nan_q  <= 1'b0;
      end else begin
         prod_q <= prod_d;
         nan_q  <= |tap_nan;
      end
   end
endmodule

// File: rtl/conv3_sum_stage.sv
module conv3_sum_stage
   import conv3_pkg::*;
#(
   parameter int TAPS  = 9,
   parameter int ACC_W = 96
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [TAPS-1:0][ACC_W-1:0]  prod,
   input  logic                        nan_in,
   input  logic [ACC_W-1:0]            chain,
   output logic [ACC_W-1:0]            sum_q,
   output logic                        nan_q
);
   logic [ACC_W-1:0] total;

   always_comb begin
      total = chain;
      for (int t = 0; t < TAPS; t++) total = total + prod[t];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
         nan_q <= 1'b0;
      end else begin
         sum_q <= total;
         nan_q <= nan_in;
      end
   end
endmodule

// File: rtl/conv3_out_format.sv
module conv3_out_format
   import conv3_pkg::*;
#(
   parameter int ACC_W = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_in,
   input  logic             raw_in,
   input  logic             nan_in,
   input  logic [ACC_W-1:0] acc,
   output logic             res_valid,
   output logic [ACC_W-1:0] res_value
);
   // leading-one position at or above this index gives a normal half value
   localparam int NORM_MIN = FRAC_W - (EXP_BIAS - 1);
   // grid position of the smallest half subnormal step
   localparam int SUB_SH   = FRAC_W - (EXP_BIAS - 1 + MAN_W);

   logic [ACC_W-1:0] mag, tmp, kept, code;
   logic             neg, guard, sticky, rnd, normal;
   logic [FP_W-1:0]  half;
   int               lead, sh;

   always_comb begin
      neg  = acc[ACC_W-1];
      mag  = neg ? (~acc + ACC_W'(1)) : acc;
      lead = 0;
      for (int i = 0; i < ACC_W; i++) if (mag[i]) lead = i;
      normal = (lead >= NORM_MIN);
      sh     = normal ? (lead - MAN_W) : SUB_SH;
      tmp    = mag >> (sh - 1);
      guard  = tmp[0];
      kept   = tmp >> 1;
      sticky = |(mag & ((ACC_W'(1) << (sh - 1)) - ACC_W'(1)));
      rnd    = guard & (sticky | kept[0]);
      kept   = kept + ACC_W'(rnd);
      // the hidden bit carries into the exponent field, including a rounding carry
      code   = normal ? (kept + (ACC_W'(lead - NORM_MIN) << MAN_W)) : kept;
      if (code >= ACC_W'(FP_INF)) code = ACC_W'(FP_INF);
      if (nan_in)
         half = FP_QNAN;
      else
         half = {neg & (mag != '0), code[FP_W-2:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_value <= '0;
      end else begin
         res_valid <= vld_in;
         if (vld_in) res_value <= raw_in ? acc : {{(ACC_W-FP_W){1'b0}}, half};
      end
   end
endmodule

// File: rtl/conv3_filter_unit.sv
module conv3_filter_unit
   import conv3_pkg::*;
#(
   parameter int KSIZE   = 3,
   parameter int LANES   = 2 * KSIZE * KSIZE - 1,
   parameter int ACC_W   = 96,
   parameter bit SKIP_EN = 1'b1,
   localparam int TAPS   = KSIZE * KSIZE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic [LANES*16-1:0]    op_data,
   input  logic [TAPS-1:0]        op_pad_mask,
   input  logic                   op_skip2,
   input  logic                   op_raw,
   input  logic [ACC_W-1:0]       op_chain_in,
   input  logic                   wt_load,
   input  logic [TAPS*16-1:0]     wt_data,
   output logic                   res_valid,
   output logic [ACC_W-1:0]       res_value
);
   localparam int LANES_MIN = SKIP_EN ? (2 * TAPS - 1) : TAPS;

   if (LANES < LANES_MIN) begin : g_lanes_bad
      $error("conv3_filter_unit: LANES too small for the selected lane picking");
   end
   if (ACC_W < ACC_MIN_W) begin : g_acc_bad
      $error("conv3_filter_unit: ACC_W cannot hold nine exact products");
   end
   if (KSIZE < 1) begin : g_k_bad
      $error("conv3_filter_unit: KSIZE must be positive");
   end

   logic [TAPS-1:0][FP_W-1:0]  x_q;
   logic [TAPS-1:0]            live_q;
   logic [TAPS-1:0][ACC_W-1:0] prod_q;
   logic                       nan_p, nan_s;
   logic [ACC_W-1:0]           sum_q;
   logic                       v1, v2, v3, raw1, raw2, raw3;
   logic [ACC_W-1:0]           chain1, chain2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {v1, v2, v3}       <= '0;
         {raw1, raw2, raw3} <= '0;
         chain1             <= '0;
         chain2             <= '0;
      end else begin
         v1   <= op_valid;
         v2   <= v1;
         v3   <= v2;
         raw2 <= raw1;
         raw3 <= raw2;
         chain2 <= chain1;
         if (op_valid) begin
            raw1   <= op_raw;
            chain1 <= op_chain_in;
         end
      end
   end

   conv3_operand_load #(.TAPS(TAPS), .LANES(LANES), .SKIP_EN(SKIP_EN)) u_load (
      .clk(clk), .rst_n(rst_n), .ld(op_valid), .data(op_data),
      .pad_mask(op_pad_mask), .skip2(op_skip2), .x_q(x_q), .live_q(live_q)
   );

   conv3_product_stage #(.TAPS(TAPS), .ACC_W(ACC_W)) u_prod (
      .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_data(wt_data),
      .x_q(x_q), .live_q(live_q), .prod_q(prod_q), .nan_q(nan_p)
   );

   conv3_sum_stage #(.TAPS(TAPS), .ACC_W(ACC_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .prod(prod_q), .nan_in(nan_p),
      .chain(chain2), .sum_q(sum_q), .nan_q(nan_s)
   );

   conv3_out_format #(.ACC_W(ACC_W)) u_fmt (
      .clk(clk), .rst_n(rst_n), .vld_in(v3), .raw_in(raw3), .nan_in(nan_s),
      .acc(sum_q), .res_valid(res_valid), .res_value(res_value)
   );
endmodule

// File: rtl/conv3_filter_unit_chk.sv
module conv3_filter_unit_chk #(
   parameter int ACC_W = 96
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic             op_raw,
   input logic             res_valid,
   input logic [ACC_W-1:0] res_value
);
   logic [2:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
   end

   // R1
   idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 3'd4) |-> !res_valid);

   // R2
   fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4) |-> (res_valid == $past(op_valid, 4)));

   // R3
   half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4 && res_valid && !$past(op_raw, 4))
      |-> (res_value[ACC_W-1:16] == '0));

   // R9
   half_inf_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4 && res_valid && !$past(op_raw, 4) && res_value[14:10] == 5'h1F)
      |-> (res_value[9:0] == '0 || res_value[15:0] == 16'h7E00));
endmodule

bind conv3_filter_unit conv3_filter_unit_chk #(.ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_raw(op_raw),
   .res_valid(res_valid), .res_value(res_value)
);

// File: tb/conv3_filter_unit_bench.sv
`timescale 1ns/1ps
module conv3_filter_unit_bench;
   localparam int TAPS  = 9;
   localparam int LANES = 17;
   localparam int ACC_W = 96;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   op_valid = 1'b0;
   logic [LANES-1:0][15:0] op_data = '0;
   logic [TAPS-1:0]        op_pad_mask = '0;
   logic                   op_skip2 = 1'b0;
   logic                   op_raw = 1'b0;
   logic [ACC_W-1:0]       op_chain_in = '0;
   logic                   wt_load = 1'b0;
   logic [TAPS-1:0][15:0]  wt_data = '0;
   logic                   res_valid;
   logic [ACC_W-1:0]       res_value;

   always #2 clk = ~clk;

   conv3_filter_unit u_conv3_filter_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_data(op_data),
      .op_pad_mask(op_pad_mask), .op_skip2(op_skip2), .op_raw(op_raw),
      .op_chain_in(op_chain_in), .wt_load(wt_load), .wt_data(wt_data),
      .res_valid(res_valid), .res_value(res_value)
   );

   int total = 0;
   int bad = 0;
   bit               pv[5];
   logic [ACC_W-1:0] pval[5];
   string            ptag[5];
   logic [15:0]      wcur[TAPS];

   function automatic real p2(int k);
      real r = 1.0;
      if (k >= 0) repeat (k) r = r * 2.0;
      else repeat (-k) r = r / 2.0;
      return r;
   endfunction

   function automatic logic [15:0] mk(bit s, int e, int m);
      return {s, 5'(e), 10'(m)};
   endfunction

   function automatic bit special(logic [15:0] c);
      return c[14:10] == 5'h1F;
   endfunction

   function automatic real f16r(logic [15:0] c);
      real r;
      if (c[14:10] == 5'd0 || c[14:10] == 5'h1F) return 0.0;
      r = real'(1024 + int'(c[9:0])) * p2(int'(c[14:10]) - 25);
      return c[15] ? -r : r;
   endfunction

   function automatic logic [15:0] to_f16(real v);
      real a, sc, f, d;
      int  e, code;
      bit  s;
      if (v == 0.0) return 16'h0000;
      s = (v < 0.0);
      a = s ? -v : v;
      e = 0;
      while (a >= p2(e + 1)) e++;
      while (a < p2(e)) e--;
      sc = (e < -14) ? a * p2(24) : a * p2(10 - e);
      f  = $floor(sc);
      d  = sc - f;
      if (d > 0.5 || (d == 0.5 && (longint'(f) % 2 == 1))) f = f + 1.0;
      code = int'(longint'(f));
      if (e >= -14) code = code + ((e + 14) << 10);
      if (code >= 32'h7C00) code = 32'h7C00;
      return {s, code[14:0]};
   endfunction

   function automatic logic [ACC_W-1:0] to_wide(real v);
      real a, hi, lo;
      logic [ACC_W-1:0] r;
      bit s;
      s  = (v < 0.0);
      a  = (s ? -v : v) * p2(48);
      hi = $floor(a / p2(48));
      lo = a - hi * p2(48);
      r  = (ACC_W'(longint'(hi)) << 48) | ACC_W'(longint'(lo));
      return s ? (~r + ACC_W'(1)) : r;
   endfunction

   task automatic put_wts(input logic [TAPS-1:0][15:0] w);
      wt_load = 1'b1;
      wt_data = w;
      for (int t = 0; t < TAPS; t++) wcur[t] = w[t];
   endtask

   task automatic put_op(input logic [LANES-1:0][15:0] d, input logic [TAPS-1:0] m,
                         input bit s2, input bit raw, input int ck, input string tag);
      real acc;
      bit  nan;
      logic [15:0] xi;
      op_valid    = 1'b1;
      op_data     = d;
      op_pad_mask = m;
      op_skip2    = s2;
      op_raw      = raw;
      op_chain_in = {{(ACC_W-32){ck[31]}}, ck} << 40;
      acc = real'(ck) / 256.0;
      nan = 1'b0;
      for (int t = 0; t < TAPS; t++) begin
         if (!m[t]) begin
            xi = s2 ? d[2*t] : d[t];
            if (special(xi) || special(wcur[t])) nan = 1'b1;
            acc = acc + f16r(xi) * f16r(wcur[t]);
         end
      end
      pv[0]   = 1'b1;
      pval[0] = raw ? to_wide(acc) : {{(ACC_W-16){1'b0}}, (nan ? 16'h7E00 : to_f16(acc))};
      ptag[0] = tag;
   endtask

   task automatic tick();
      @(posedge clk);
      for (int k = 4; k > 0; k--) begin
         pv[k] = pv[k-1]; pval[k] = pval[k-1]; ptag[k] = ptag[k-1];
      end
      pv[0] = 1'b0;
      ptag[0] = "R2 idle";
      @(negedge clk);
      total++;
      if (res_valid !== pv[4]) begin
         bad++;
         $display("FAIL R2 (%s): res_valid=%0b expected %0b", ptag[4], res_valid, pv[4]);
      end
      if (pv[4]) begin
         total++;
         if (res_value !== pval[4]) begin
            bad++;
            $display("FAIL %s: res_value=%h expected %h", ptag[4], res_value, pval[4]);
         end
      end
      op_valid = 1'b0;
      wt_load  = 1'b0;
   endtask

   function automatic logic [15:0] rnd_half();
      if ($urandom % 16 == 0) return mk($urandom % 2, 0, $urandom % 1024);
      return mk($urandom % 2, 10 + int'($urandom % 11), $urandom % 1024);
   endfunction

   function automatic logic [TAPS-1:0][15:0] all_w(logic [15:0] c);
      logic [TAPS-1:0][15:0] w;
      for (int t = 0; t < TAPS; t++) w[t] = c;
      return w;
   endfunction

   initial begin
      #(4 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: run still busy, expected it finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [LANES-1:0][15:0] d;
      logic [TAPS-1:0][15:0]  w;
      for (int k = 0; k < 5; k++) begin pv[k] = 1'b0; pval[k] = '0; ptag[k] = "R2 idle"; end
      for (int t = 0; t < TAPS; t++) wcur[t] = 16'h0000;

      // R1: outputs quiet during reset
      repeat (3) begin
         @(negedge clk);
         total++;
         if (res_valid !== 1'b0 || res_value !== '0) begin
            bad++;
            $display("FAIL R1: res_valid=%0b res_value=%h expected 0 0", res_valid, res_value);
         end
      end
      rst_n = 1'b1;
      repeat (3) tick();

      // R3 / R4: plain sums with unit weights
      put_wts(all_w(16'h3C00)); tick();
      for (int k = 0; k < LANES; k++) d[k] = to_f16(real'(k + 1));
      put_op(d, '0, 1'b0, 1'b0, 0, "R3 plain sum");       tick();
      put_op(d, '0, 1'b0, 1'b1, 0, "R4 wide plain sum");   tick();
      // R7: skip-two lane pick
      put_op(d, '0, 1'b1, 1'b0, 0, "R7 skip2 lanes");      tick();
      put_op(d, '0, 1'b1, 1'b1, 0, "R7 skip2 lanes wide"); tick();
      // R6: pad mask, with special value behind a masked tap
      d[3] = 16'h7C00;
      put_op(d, 9'b0_0000_1000, 1'b0, 1'b0, 0, "R6 masked special tap"); tick();
      put_op(d, 9'b1_0101_1010, 1'b0, 1'b0, 0, "R6 pad mask");           tick();
      // R11: unmasked special operand
      put_op(d, '0, 1'b0, 1'b0, 0, "R11 special operand");   tick();
      put_op(d, '0, 1'b0, 1'b1, 0, "R11 special in wide");   tick();
      // R5: chain input
      for (int k = 0; k < LANES; k++) d[k] = to_f16(real'(k) * 0.75);
      put_op(d, '0, 1'b0, 1'b0, -9000, "R5 chain add");      tick();
      put_op(d, '0, 1'b0, 1'b1, 123457, "R5 chain add wide"); tick();
      // R8: subnormal operands flushed
      d = '0; d[0] = 16'h0200; d[1] = 16'h3C00;
      put_op(d, '0, 1'b0, 1'b0, 0, "R8 subnormal data"); tick();
      w = all_w(16'h3C00); w[1] = 16'h0001;
      put_wts(w);
      put_op(d, '0, 1'b0, 1'b1, 0, "R8 subnormal weight"); tick();
      // R3: ties to even and just above a tie
      put_wts(all_w(16'h3C00));
      d = '0; d[0] = 16'h3C00; d[1] = mk(0, 4, 0);
      put_op(d, '0, 1'b0, 1'b0, 0, "R3 tie to even"); tick();
      d[2] = mk(0, 1, 0);
      put_op(d, '0, 1'b0, 1'b0, 0, "R3 above tie");   tick();
      // R3: subnormal result
      w = '0; w[0] = mk(0, 5, 0);
      put_wts(w);
      d = '0; d[0] = mk(1, 5, 0);
      put_op(d, '0, 1'b0, 1'b0, 0, "R3 subnormal result"); tick();
      // R9: overflow to infinities
      put_wts(all_w(16'h7BFF));
      for (int k = 0; k < LANES; k++) d[k] = 16'h7BFF;
      put_op(d, '0, 1'b0, 1'b0, 0, "R9 positive overflow"); tick();
      for (int k = 0; k < LANES; k++) d[k] = 16'hFBFF;
      put_op(d, '0, 1'b0, 1'b0, 0, "R9 negative overflow"); tick();
      put_op(d, '0, 1'b0, 1'b1, 0, "R9 overflow wide");     tick();
      // R10: weight timing
      for (int k = 0; k < LANES; k++) d[k] = to_f16(real'(k + 1));
      put_wts(all_w(16'h4000)); tick();
      put_wts(all_w(16'h4200));
      put_op(d, '0, 1'b0, 1'b0, 0, "R10 same-cycle load"); tick();
      put_op(d, '0, 1'b0, 1'b0, 0, "R10 later load ignored"); tick();
      put_wts(all_w(16'hC400)); tick();
      put_op(d, '0, 1'b0, 1'b0, 0, "R10 held weights"); tick();
      repeat (4) tick();

      // R2: back-to-back random stream in both formats
      for (int n = 0; n < 2000; n++) begin
         if ($urandom % 8 == 0) begin
            for (int t = 0; t < TAPS; t++) w[t] = rnd_half();
            put_wts(w);
         end
         if ($urandom % 5 != 0) begin
            for (int k = 0; k < LANES; k++) d[k] = rnd_half();
            put_op(d, ($urandom % 3 == 0) ? TAPS'($urandom) : '0, bit'($urandom % 2),
                   bit'($urandom % 2), int'($urandom % 2001) - 1000, "R2 R3 R4 stream");
         end
         tick();
      end
      repeat (6) tick();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule